// File: doc/BRIEF.md
# LED Selector Register File

This block is a register file for driving sixteen LED or general-purpose output pins. It sits behind a byte-level serial-slave transaction front end. The front end gives it three things: a strobe for each bus start or stop event, a strobe for each byte written (with its data), and a strobe for each byte read. During a read strobe the block presents the read data combinationally.

After any bus event, the first written byte is taken as a register pointer. Each later byte writes the register that the pointer selects, and each read strobe returns that register. The low four pointer bits select the register. Pointer bit 4 requests auto-increment, which wraps the index after the last selector register.

Every pin has a two-bit mode, held in one of four selector registers. The on and off modes drive the pin high or low. The two blink modes hold the pin at its present level; no waveform is generated. The driven levels are mirrored into two read-only input registers. Whenever a selector write changes at least one pin level, the block raises a one-cycle change strobe together with the mask of the pins that moved.

Top module: `led_sel_regfile`

## Requirements
- R1: After reset the pointer is 0xFF and all pins are driven low. Prescaler registers (index 2 and 4) read 0xFF, duty registers (index 3 and 5) read 0x80, and selector registers (index 6..9) read 0x55, which puts every pin in the off mode.
- R2: The first byte written after a bus event loads the 8-bit pointer. Each further written byte stores into the register at pointer bits [3:0].
- R3: A bus event re-arms pointer capture, so the next written byte is again a pointer, even in the middle of a transfer.
- R4: The register map is: input 0 = 0, input 1 = 1, prescaler 0 = 2, duty 0 = 3, prescaler 1 = 4, duty 1 = 5, selectors 0..3 = 6..9. With pointer bit 4 clear, the pointer does not move on reads or writes.
- R5: With pointer bit 4 set and the pointer not 0xFF, each data byte read or written sets the pointer to {3'b000, 1'b1, (index+1) mod 10}.
- R6: A pointer of 0xFF never auto-increments.
- R7: Pin n takes its mode from selector register n/4, bits [2*(n%4)+1 : 2*(n%4)]. The codes are 00 = on (drive 1), 01 = off (drive 0), 10 = blink 0, 11 = blink 1.
- R8: A pin in either blink mode keeps its previous level. The prescaler and duty registers are stored and read back, and have no effect on the pins.
- R9: Pin n is readable at register n/8, bit n%8. Writes to the input registers leave both the pins and the read-back unchanged.
- R10: In the cycle after a selector write, the change strobe is high exactly when some pin level changed, and the mask equals the old levels XOR the new levels. Writes to other registers never raise the strobe.
- R11: Reading an index from 10 to 15 returns 0x00. Writing one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_evt_i | input | 1 | Bus start/stop event strobe |
| wr_stb_i | input | 1 | Written-byte strobe |
| wr_data_i | input | 8 | Written byte |
| rd_stb_i | input | 1 | Read-byte strobe |
| rd_data_o | output | 8 | Data of the register at the pointer |
| pin_o | output | NUM_PINS | Driven pin levels |
| pin_chg_o | output | 1 | One-cycle pin-change strobe |
| pin_chg_mask_o | output | NUM_PINS | Pins that changed, valid with the strobe |

## Verification
The bench builds the block with the default of 16 pins. This gives two input registers, four selector registers and a last index of 9. The wrap from index 9 back to index 0 is therefore reachable on both reads and writes. It also leaves indices 10 to 15 free for the unmapped-access cases. With only sixteen pins, each pin mode and the change mask can be compared against full 16-bit expected words.

// File: rtl/led_sel_pkg.sv
package led_sel_pkg;
  typedef enum logic [1:0] {
    MODE_ON   = 2'b00,
    MODE_OFF  = 2'b01,
    MODE_BLK0 = 2'b10,
    MODE_BLK1 = 2'b11
  } pin_mode_e;

  localparam logic [7:0] PTR_IDLE = 8'hFF;
  localparam int         IDX_W    = 4;
  localparam int         AINC_BIT = 4;
  localparam int         NUM_CTRL = 4;
endpackage

// File: rtl/ledsel_ptr.sv
module ledsel_ptr
  import led_sel_pkg::*;
#(
  parameter int LAST_IDX = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             data_we_o
);
  localparam int MOD = LAST_IDX + 1;

  logic             first_q;
  logic [7:0]       ptr_q;
  logic             load_ptr, step;
  logic [IDX_W:0]   sum;
  logic [IDX_W-1:0] idx_wrap;

  assign idx_o     = ptr_q[IDX_W-1:0];
  assign load_ptr  = wr_i && first_q && !evt_i;
  assign data_we_o = wr_i && !first_q && !evt_i;
  assign step      = (rd_i || data_we_o) && !evt_i && (ptr_q != PTR_IDLE) && ptr_q[AINC_BIT];
  assign sum       = {1'b0, idx_o} + 1'b1;
  assign idx_wrap  = IDX_W'(sum % (IDX_W+1)'(MOD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      ptr_q   <= PTR_IDLE;
    end else begin
      if (evt_i)         first_q <= 1'b1;
      else if (load_ptr) first_q <= 1'b0;
      if (load_ptr)  ptr_q <= wdata_i;
      else if (step) ptr_q <= {3'b000, 1'b1, idx_wrap};
    end
  end

  // R2
  load_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && first_q && !evt_i) |=> (ptr_q == $past(wdata_i)));
  // R3
  evt_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !wr_i) |=> (wr_i |-> !data_we_o));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == PTR_IDLE && !load_ptr) |=> (ptr_q == PTR_IDLE));
  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && (rd_i || data_we_o) && ptr_q[AINC_BIT] && ptr_q != PTR_IDLE
     && int'(idx_o) == LAST_IDX) |=> (ptr_q == 8'h10));
endmodule

// File: rtl/ledsel_regs.sv
module ledsel_regs
  import led_sel_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [7:0]                   wdata_i,
  output logic [NUM_CTRL-1:0][7:0]     ctrl_o,
  output logic [NUM_PINS/4-1:0][7:0]   sel_o,
  output logic [NUM_PINS/4-1:0][7:0]   sel_nxt_o,
  output logic                         sel_we_o
);
  localparam int NUM_IN    = NUM_PINS / 8;
  localparam int NUM_SEL   = NUM_PINS / 4;
  localparam int CTRL_BASE = NUM_IN;
  localparam int SEL_BASE  = NUM_IN + NUM_CTRL;

  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
    // even slots are prescalers, odd slots duty values
    localparam logic [7:0] RST_V = (c % 2 == 0) ? 8'hFF : 8'h80;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ctrl_o[c] <= RST_V;
      else if (we_i && int'(idx_i) == CTRL_BASE + c)  ctrl_o[c] <= wdata_i;
    end
  end

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    logic hit;
    assign hit = we_i && int'(idx_i) == SEL_BASE + s;
    assign sel_nxt_o[s] = hit ? wdata_i : sel_o[s];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  sel_o[s] <= 8'h55;
      else if (hit) sel_o[s] <= wdata_i;
    end
  end

  assign sel_we_o = we_i && int'(idx_i) >= SEL_BASE && int'(idx_i) < SEL_BASE + NUM_SEL;

  // R11
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(idx_i) >= SEL_BASE + NUM_SEL) |=> ($stable(ctrl_o) && $stable(sel_o)));
endmodule

// File: rtl/ledsel_pins.sv
module ledsel_pins
  import led_sel_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sel_we_i,
  input  logic [NUM_PINS/4-1:0][7:0] sel_nxt_i,
  output logic [NUM_PINS-1:0]        pin_o,
  output logic                       chg_o,
  output logic [NUM_PINS-1:0]        chg_mask_o
);
  logic [NUM_PINS-1:0] pin_nxt, diff;

  always_comb begin
    for (int n = 0; n < NUM_PINS; n++) begin
      pin_mode_e m;
      m = pin_mode_e'(sel_nxt_i[n/4][2*(n%4) +: 2]);
      unique case (m)
        MODE_ON:  pin_nxt[n] = 1'b1;
        MODE_OFF: pin_nxt[n] = 1'b0;
        default:  pin_nxt[n] = pin_o[n];
      endcase
    end
  end

  assign diff = pin_o ^ pin_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o      <= '0;
      chg_o      <= 1'b0;
      chg_mask_o <= '0;
    end else if (sel_we_i) begin
      pin_o      <= pin_nxt;
      chg_o      <= |diff;
      chg_mask_o <= diff;
    end else begin
      chg_o      <= 1'b0;
      chg_mask_o <= '0;
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
    // R7
    pin_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_we_i && sel_nxt_i[n/4][2*(n%4) +: 2] == 2'b00) |=> pin_o[n]);
    // R8
    pin_blink_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_we_i && sel_nxt_i[n/4][2*(n%4) +: 1] == 1'b0 && sel_nxt_i[n/4][2*(n%4)+1])
      |=> $stable(pin_o[n]));
  end

  // R9
  pin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(pin_o));
  // R10
  chg_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> ($past(sel_we_i) && chg_mask_o == (pin_o ^ $past(pin_o))));
endmodule

// File: rtl/ledsel_rdmux.sv
module ledsel_rdmux
  import led_sel_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [NUM_PINS-1:0]        pin_i,
  input  logic [NUM_CTRL-1:0][7:0]   ctrl_i,
  input  logic [NUM_PINS/4-1:0][7:0] sel_i,
  output logic [7:0]                 rdata_o
);
  localparam int NUM_IN   = NUM_PINS / 8;
  localparam int NUM_SEL  = NUM_PINS / 4;
  localparam int SEL_BASE = NUM_IN + NUM_CTRL;

  always_comb begin
    rdata_o = 8'h00;
    for (int k = 0; k < NUM_IN; k++)
      if (int'(idx_i) == k) rdata_o = pin_i[8*k +: 8];
    for (int c = 0; c < NUM_CTRL; c++)
      if (int'(idx_i) == NUM_IN + c) rdata_o = ctrl_i[c];
    for (int s = 0; s < NUM_SEL; s++)
      if (int'(idx_i) == SEL_BASE + s) rdata_o = sel_i[s];
  end
endmodule

// File: rtl/led_sel_regfile.sv
module led_sel_regfile
  import led_sel_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_evt_i,
  input  logic                wr_stb_i,
  input  logic [7:0]          wr_data_i,
  input  logic                rd_stb_i,
  output logic [7:0]          rd_data_o,
  output logic [NUM_PINS-1:0] pin_o,
  output logic                pin_chg_o,
  output logic [NUM_PINS-1:0] pin_chg_mask_o
);
  localparam int NUM_SEL  = NUM_PINS / 4;
  localparam int LAST_IDX = NUM_PINS / 8 + NUM_CTRL + NUM_SEL - 1;

  logic [IDX_W-1:0]          idx;
  logic                      data_we, sel_we;
  logic [NUM_CTRL-1:0][7:0]  ctrl;
  logic [NUM_SEL-1:0][7:0]   sel, sel_nxt;

  ledsel_ptr #(.LAST_IDX(LAST_IDX)) i_ptr (
    .clk_i, .rst_ni,
    .evt_i     (bus_evt_i),
    .wr_i      (wr_stb_i),
    .rd_i      (rd_stb_i),
    .wdata_i   (wr_data_i),
    .idx_o     (idx),
    .data_we_o (data_we)
  );

  ledsel_regs #(.NUM_PINS(NUM_PINS)) i_regs (
    .clk_i, .rst_ni,
    .we_i      (data_we),
    .idx_i     (idx),
    .wdata_i   (wr_data_i),
    .ctrl_o    (ctrl),
    .sel_o     (sel),
    .sel_nxt_o (sel_nxt),
    .sel_we_o  (sel_we)
  );

  ledsel_pins #(.NUM_PINS(NUM_PINS)) i_pins (
    .clk_i, .rst_ni,
    .sel_we_i   (sel_we),
    .sel_nxt_i  (sel_nxt),
    .pin_o      (pin_o),
    .chg_o      (pin_chg_o),
    .chg_mask_o (pin_chg_mask_o)
  );

  ledsel_rdmux #(.NUM_PINS(NUM_PINS)) i_rdmux (
    .idx_i   (idx),
    .pin_i   (pin_o),
    .ctrl_i  (ctrl),
    .sel_i   (sel),
    .rdata_o (rd_data_o)
  );

  // R1
  reset_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pin_o == '0 && !pin_chg_o));
endmodule

// File: tb/test_led_sel_regfile.sv
`timescale 1ns/1ps
module test_led_sel_regfile;
  localparam int OP_EVT = 0, OP_WR = 1, OP_RD = 2;
  localparam int NV = 47;
  // {req[3:0], op[1:0], data[7:0], expected read[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {4'd1,  2'd2, 8'h00, 8'h00},  // R1 pointer idle reads zero
    {4'd6,  2'd2, 8'h00, 8'h00},  // R6 no increment at 0xFF
    {4'd0,  2'd0, 8'h00, 8'h00},
    {4'd0,  2'd1, 8'h12, 8'h00},
    {4'd5,  2'd2, 8'h00, 8'hFF},
    {4'd5,  2'd2, 8'h00, 8'h80},
    {4'd5,  2'd2, 8'h00, 8'hFF},
    {4'd5,  2'd2, 8'h00, 8'h80},
    {4'd1,  2'd2, 8'h00, 8'h55},
    {4'd1,  2'd2, 8'h00, 8'h55},
    {4'd1,  2'd2, 8'h00, 8'h55},
    {4'd1,  2'd2, 8'h00, 8'h55},
    {4'd5,  2'd2, 8'h00, 8'h00},  // wrap to index 0
    {4'd5,  2'd2, 8'h00, 8'h00},
    {4'd5,  2'd2, 8'h00, 8'hFF},
    {4'd0,  2'd0, 8'h00, 8'h00},
    {4'd0,  2'd1, 8'h03, 8'h00},
    {4'd0,  2'd1, 8'h3C, 8'h00},
    {4'd4,  2'd2, 8'h00, 8'h3C},  // R4 no increment
    {4'd4,  2'd2, 8'h00, 8'h3C},
    {4'd0,  2'd0, 8'h00, 8'h00},
    {4'd0,  2'd1, 8'h00, 8'h00},
    {4'd0,  2'd1, 8'hAA, 8'h00},
    {4'd9,  2'd2, 8'h00, 8'h00},  // R9 input write ignored
    {4'd0,  2'd0, 8'h00, 8'h00},
    {4'd0,  2'd1, 8'h0C, 8'h00},
    {4'd11, 2'd2, 8'h00, 8'h00},  // R11
    {4'd0,  2'd1, 8'h77, 8'h00},
    {4'd11, 2'd2, 8'h00, 8'h00},
    {4'd0,  2'd0, 8'h00, 8'h00},
    {4'd0,  2'd1, 8'h14, 8'h00},
    {4'd0,  2'd1, 8'h11, 8'h00},
    {4'd0,  2'd0, 8'h00, 8'h00},  // R3 event mid-transfer
    {4'd0,  2'd1, 8'h04, 8'h00},
    {4'd2,  2'd2, 8'h00, 8'h11},  // R2 R3
    {4'd0,  2'd0, 8'h00, 8'h00},
    {4'd0,  2'd1, 8'h19, 8'h00},
    {4'd0,  2'd1, 8'h55, 8'h00},
    {4'd0,  2'd1, 8'h99, 8'h00},
    {4'd0,  2'd0, 8'h00, 8'h00},
    {4'd0,  2'd1, 8'h19, 8'h00},
    {4'd5,  2'd2, 8'h00, 8'h55},
    {4'd9,  2'd2, 8'h00, 8'h00},
    {4'd0,  2'd0, 8'h00, 8'h00},
    {4'd0,  2'd1, 8'hF3, 8'h00},
    {4'd4,  2'd2, 8'h00, 8'h3C},  // upper pointer bits ignored
    {4'd5,  2'd2, 8'h00, 8'h11}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_evt = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [15:0] pin, chg_mask;
  logic        pin_chg;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  led_sel_regfile i_led_sel_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .bus_evt_i(bus_evt), .wr_stb_i(wr_stb),
    .wr_data_i(wr_data), .rd_stb_i(rd_stb), .rd_data_o(rd_data),
    .pin_o(pin), .pin_chg_o(pin_chg), .pin_chg_mask_o(chg_mask)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic op(input int kind, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    bus_evt = (kind == OP_EVT);
    wr_stb  = (kind == OP_WR);
    rd_stb  = (kind == OP_RD);
    wr_data = d;
    #1 q = rd_data;
    @(posedge clk);
    #1 bus_evt = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic sel_wr(input logic [7:0] p, input logic [7:0] d);
    logic [7:0] q;
    op(OP_EVT, 8'h00, q);
    op(OP_WR, p, q);
    op(OP_WR, d, q);
  endtask

  task automatic rd_reg(input logic [7:0] p, output logic [7:0] q);
    op(OP_EVT, 8'h00, q);
    op(OP_WR, p, q);
    op(OP_RD, 8'h00, q);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 pins", pin, 16'h0000);
    chk("R1 chg", {15'd0, pin_chg}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      op(int'(VEC[i][17:16]), VEC[i][15:8], q);
      if (int'(VEC[i][17:16]) == OP_RD)
        chk($sformatf("R%0d vec %0d", VEC[i][21:18], i), {8'h00, q}, {8'h00, VEC[i][7:0]});
    end

    // R7 R10: pins 0..3 on
    sel_wr(8'h06, 8'h00);
    chk("R7 pins", pin, 16'h000F);
    chk("R10 strobe", {15'd0, pin_chg}, 16'h0001);
    chk("R10 mask", chg_mask, 16'h000F);
    @(posedge clk); #1;
    chk("R10 strobe one cycle", {15'd0, pin_chg}, 16'h0000);
    rd_reg(8'h00, q);
    chk("R9 input0", {8'h00, q}, 16'h000F);
    // R7: pin 15 on through field [7:6] of selector 3
    sel_wr(8'h09, 8'h15);
    chk("R7 pin15", pin, 16'h800F);
    chk("R10 mask pin15", chg_mask, 16'h8000);
    rd_reg(8'h01, q);
    chk("R9 input1", {8'h00, q}, 16'h0080);
    // R8: pins 0,1 blink hold high, pin 2 on, pin 3 off
    sel_wr(8'h06, 8'h4E);
    chk("R8 blink hold", pin, 16'h8007);
    chk("R10 mask pin3", chg_mask, 16'h0008);
    sel_wr(8'h06, 8'h4E);
    chk("R10 no change strobe", {15'd0, pin_chg}, 16'h0000);
    chk("R10 no change mask", chg_mask, 16'h0000);
    sel_wr(8'h07, 8'hAA);
    chk("R8 blink hold low", pin, 16'h8007);
    chk("R10 blink no strobe", {15'd0, pin_chg}, 16'h0000);
    sel_wr(8'h02, 8'h33);
    chk("R10 prescaler no strobe", {15'd0, pin_chg}, 16'h0000);
    chk("R8 prescaler no effect", pin, 16'h8007);
    rd_reg(8'h02, q);
    chk("R8 prescaler stored", {8'h00, q}, 16'h0033);
    sel_wr(8'h00, 8'hFF);
    chk("R9 input write pins", pin, 16'h8007);
    rd_reg(8'h00, q);
    chk("R9 input write readback", {8'h00, q}, 16'h0007);
    rd_reg(8'h06, q);
    chk("R7 selector readback", {8'h00, q}, 16'h004E);

    // R1: asynchronous reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    #1 chk("R1 async pins", pin, 16'h0000);
    @(negedge clk); rst_ni = 1'b1;
    op(OP_RD, 8'h00, q);
    chk("R1 pointer idle", {8'h00, q}, 16'h0000);
    rd_reg(8'h06, q);
    chk("R1 selector reset", {8'h00, q}, 16'h0055);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule